// File: doc/BRIEF.md
# Tweakable AES Round Engine

This block applies a keyed, tweak-dependent transformation to one 128-bit block. On an accepted start it whitens the input block with an offset word, runs a mode-dependent number of AES rounds through one combinational round stage that feeds an iterative state register, and may whiten the result again with the same offset. The offset arrives already computed. The engine keeps its own copy of the offset, so the logic that computes offsets is free to prepare the value for the next block while the current one is in flight.

Round keys are not expanded in the usual way. They are drawn from three 128-bit key words, here called key_a, key_b and key_c, or are zero. A small selection table picks one of these from the round number and a key-set type. The key-set type and the round count both follow from a 3-bit mode code.

Top module: `tweak_round_engine`

## Requirements
- R1: After reset, done is 0 and y_out is all zeros.
- R2: With start sampled high at clock edge k while idle, done is high for the cycle after edge k+N, where N is 4 for modes 0 to 6 and 10 for mode 7. The whole operation therefore takes N+1 cycles: one load cycle and N round cycles.
- R3: The mode selects the key set. Mode 2 uses set B, mode 7 uses the full set, and every other mode uses set A. For rounds 1 to 4, set A gives key_b, key_a, key_c, zero and set B gives zero, key_a, key_b, key_c. In round r of the full set, key_a is used when r mod 3 is 1, key_b when r mod 3 is 2, and key_c when r mod 3 is 0.
- R4: The load cycle stores x_in XOR delta_in. Each round applies SubBytes, ShiftRows, MixColumns and the round-key XOR, in that order, with MixColumns present in every round. Byte k of the AES state (column k/4, row k mod 4) occupies bits [127-8k -: 8].
- R5: In modes 3, 4, 5 and 6 only, the result of the last round is XORed with the captured offset before it appears on y_out.
- R6: The offset and mode are captured when start is accepted. Changes on delta_in, x_in or mode during the operation have no effect on the result.
- R7: A start that arrives while an operation is running is ignored. It neither restarts the operation nor changes its result or latency.
- R8: done is a single-cycle pulse. While idle with no start, y_out keeps the last result.
- R9: A start in the same cycle as the done pulse is accepted, and the new operation runs with the latency given in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation when idle |
| mode | input | 3 | Mode code selecting round count, key set and final whitening |
| x_in | input | 128 | Input block |
| delta_in | input | 128 | Precomputed offset |
| key_a | input | 128 | First key word |
| key_b | input | 128 | Second key word |
| key_c | input | 128 | Third key word |
| y_out | output | 128 | Result block |
| done | output | 1 | One-cycle pulse when y_out holds a new result |

## Verification
The completion pulse and the acceptance of the next start can fall in the same cycle. The bench provokes this by issuing most operations back to back, raising start in the very cycle done is seen. It judges the outcome by checking that the new operation takes exactly N+1 cycles and produces the value computed by the bench model. Other operations insert idle gaps instead, and during those gaps the bench confirms that done stays low and y_out holds.

// File: rtl/tre_pkg.sv
package tre_pkg;
    parameter int BLK_W        = 128;
    parameter int ROUNDS_SHORT = 4;
    parameter int ROUNDS_LONG  = 10;
    parameter int MODE_W       = 3;
    localparam int RND_W       = $clog2(ROUNDS_LONG + 1);
    localparam int NBYTES      = BLK_W / 8;

    typedef enum logic [1:0] {KS_A = 2'd0, KS_B = 2'd1, KS_FULL = 2'd2} kset_e;
    typedef enum logic [1:0] {KW_ZERO = 2'd0, KW_A = 2'd1, KW_B = 2'd2, KW_C = 2'd3} kword_e;

    typedef struct packed {
        logic [RND_W-1:0] last;
        kset_e            kset;
        logic             fin;
    } mode_info_t;

    function automatic mode_info_t decode_mode(input logic [MODE_W-1:0] m);
        mode_info_t info;
        info.last = (m == 3'd7) ? RND_W'(ROUNDS_LONG) : RND_W'(ROUNDS_SHORT);
        info.kset = (m == 3'd7) ? KS_FULL : ((m == 3'd2) ? KS_B : KS_A);
        info.fin  = (m >= 3'd3) && (m <= 3'd6);
        return info;
    endfunction

    function automatic kword_e pick_word(input logic [RND_W-1:0] r, input kset_e ks);
        kword_e w;
        w = KW_ZERO;
        case (ks)
            KS_A: case (r)
                RND_W'(1): w = KW_B;
                RND_W'(2): w = KW_A;
                RND_W'(3): w = KW_C;
                default:   w = KW_ZERO;
            endcase
            KS_B: case (r)
                RND_W'(2): w = KW_A;
                RND_W'(3): w = KW_B;
                RND_W'(4): w = KW_C;
                default:   w = KW_ZERO;
            endcase
            default: case (r % RND_W'(3))
                RND_W'(1): w = KW_A;
                RND_W'(2): w = KW_B;
                default:   w = KW_C;
            endcase
        endcase
        return w;
    endfunction

    function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] acc;
        logic [7:0] sh;
        acc = 8'h00;
        sh  = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = {sh[6:0], 1'b0} ^ (sh[7] ? 8'h1b : 8'h00);
        end
        return acc;
    endfunction

    function automatic logic [7:0] sub_byte(input logic [7:0] a);
        logic [7:0] inv;
        logic [7:0] pw;
        inv = 8'h01;
        pw  = a;
        for (int i = 1; i < 8; i++) begin
            pw  = gf_mul(pw, pw);
            inv = gf_mul(inv, pw);
        end
        return inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]}
                   ^ {inv[4:0], inv[7:5]} ^ {inv[3:0], inv[7:4]} ^ 8'h63;
    endfunction
endpackage

// File: rtl/tre_keysel.sv
module tre_keysel
    import tre_pkg::*;
(
    input  logic [RND_W-1:0] rnd,
    input  kset_e            kset,
    input  logic [BLK_W-1:0] word_a,
    input  logic [BLK_W-1:0] word_b,
    input  logic [BLK_W-1:0] word_c,
    output logic [BLK_W-1:0] rkey
);
    kword_e sel;

    always_comb begin
        sel = pick_word(rnd, kset);
        case (sel)
            KW_A:    rkey = word_a;
            KW_B:    rkey = word_b;
            KW_C:    rkey = word_c;
            default: rkey = '0;
        endcase
    end
endmodule

// File: rtl/tre_round.sv
module tre_round
    import tre_pkg::*;
(
    input  logic [BLK_W-1:0] st_in,
    input  logic [BLK_W-1:0] rkey,
    output logic [BLK_W-1:0] st_out
);
    logic [7:0] sb  [NBYTES];
    logic [7:0] sr  [NBYTES];
    logic [7:0] mc  [NBYTES];

    genvar k;
    generate
        for (k = 0; k < NBYTES; k++) begin : g_sbox
            assign sb[k] = sub_byte(st_in[BLK_W-1-8*k -: 8]);
        end
        for (k = 0; k < NBYTES; k++) begin : g_shift
            localparam int ROW = k % 4;
            localparam int COL = k / 4;
            assign sr[k] = sb[ROW + 4 * ((COL + ROW) % 4)];
        end
        for (k = 0; k < NBYTES / 4; k++) begin : g_mix
            assign mc[4*k+0] = gf_mul(sr[4*k+0], 8'h02) ^ gf_mul(sr[4*k+1], 8'h03) ^ sr[4*k+2] ^ sr[4*k+3];
            assign mc[4*k+1] = sr[4*k+0] ^ gf_mul(sr[4*k+1], 8'h02) ^ gf_mul(sr[4*k+2], 8'h03) ^ sr[4*k+3];
            assign mc[4*k+2] = sr[4*k+0] ^ sr[4*k+1] ^ gf_mul(sr[4*k+2], 8'h02) ^ gf_mul(sr[4*k+3], 8'h03);
            assign mc[4*k+3] = gf_mul(sr[4*k+0], 8'h03) ^ sr[4*k+1] ^ sr[4*k+2] ^ gf_mul(sr[4*k+3], 8'h02);
        end
        for (k = 0; k < NBYTES; k++) begin : g_ark
            assign st_out[BLK_W-1-8*k -: 8] = mc[k] ^ rkey[BLK_W-1-8*k -: 8];
        end
    endgenerate
endmodule

// File: rtl/tweak_round_engine.sv
module tweak_round_engine
    import tre_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [MODE_W-1:0] mode,
    input  logic [BLK_W-1:0]  x_in,
    input  logic [BLK_W-1:0]  delta_in,
    input  logic [BLK_W-1:0]  key_a,
    input  logic [BLK_W-1:0]  key_b,
    input  logic [BLK_W-1:0]  key_c,
    output logic [BLK_W-1:0]  y_out,
    output logic              done
);
    typedef struct packed {
        logic [BLK_W-1:0] state;
        logic [BLK_W-1:0] delta;
        logic [RND_W-1:0] rnd;
        logic [RND_W-1:0] last;
        kset_e            kset;
        logic             fin;
        logic             busy;
        logic             done;
    } eng_t;

    eng_t st_d, st_q;
    logic [BLK_W-1:0] rkey;
    logic [BLK_W-1:0] rnd_out;
    mode_info_t       info;
    logic             busy_w;
    logic [RND_W-1:0] rnd_w;

    tre_keysel u_keysel (
        .rnd    (st_q.rnd),
        .kset   (st_q.kset),
        .word_a (key_a),
        .word_b (key_b),
        .word_c (key_c),
        .rkey   (rkey)
    );

    tre_round u_round (
        .st_in  (st_q.state),
        .rkey   (rkey),
        .st_out (rnd_out)
    );

    always_comb begin
        info      = decode_mode(mode);
        st_d      = st_q;
        st_d.done = 1'b0;
        if (!st_q.busy) begin
            if (start) begin
                st_d.state = x_in ^ delta_in;
                st_d.delta = delta_in;
                st_d.rnd   = RND_W'(1);
                st_d.last  = info.last;
                st_d.kset  = info.kset;
                st_d.fin   = info.fin;
                st_d.busy  = 1'b1;
            end
        end else begin
            st_d.rnd = st_q.rnd + RND_W'(1);
            if (st_q.rnd == st_q.last) begin
                st_d.state = st_q.fin ? (rnd_out ^ st_q.delta) : rnd_out;
                st_d.busy  = 1'b0;
                st_d.done  = 1'b1;
            end else begin
                st_d.state = rnd_out;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign y_out  = st_q.state;
    assign done   = st_q.done;
    assign busy_w = st_q.busy;
    assign rnd_w  = st_q.rnd;
endmodule

// File: rtl/tre_props.sv
module tre_props
    import tre_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [MODE_W-1:0] mode,
    input logic [BLK_W-1:0]  y_out,
    input logic              done,
    input logic              busy,
    input logic [RND_W-1:0]  rnd
);
    logic [4:0] cyc_q;
    logic       long_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc_q  <= '0;
            long_q <= 1'b0;
        end else if (start && !busy) begin
            cyc_q  <= 5'd1;
            long_q <= (mode == 3'd7);
        end else if (busy) begin
            cyc_q  <= cyc_q + 5'd1;
        end
    end

    // R2
    latency_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cyc_q == (long_q ? 5'(ROUNDS_LONG + 1) : 5'(ROUNDS_SHORT + 1))));

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(y_out));

    // R7
    busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !done) |=> (done || (rnd == $past(rnd) + RND_W'(1))));

    // R9
    done_then_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && start) |=> (busy && rnd == RND_W'(1)));
endmodule

bind tweak_round_engine tre_props u_props (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .mode  (mode),
    .y_out (y_out),
    .done  (done),
    .busy  (busy_w),
    .rnd   (rnd_w)
);

// File: tb/sim_tweak_round_engine.sv
`timescale 1ns/1ps
module sim_tweak_round_engine;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [2:0]   mode = '0;
    logic [127:0] x_in = '0, delta_in = '0;
    logic [127:0] key_a = '0, key_b = '0, key_c = '0;
    logic [127:0] y_out;
    logic         done;

    int checks = 0;
    int fails  = 0;
    logic [7:0]   sbx [256];
    logic [127:0] prev_exp = '0;

    always #2.5 clk = ~clk;

    tweak_round_engine u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .x_in(x_in), .delta_in(delta_in),
        .key_a(key_a), .key_b(key_b), .key_c(key_c),
        .y_out(y_out), .done(done)
    );

    function automatic logic [7:0] xt(input logic [7:0] v);
        return (v << 1) ^ (v[7] ? 8'h1b : 8'h00);
    endfunction

    function automatic logic [7:0] mul_slow(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] r = 0;
        logic [7:0] t = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) r ^= t;
            t = xt(t);
        end
        return r;
    endfunction

    function automatic logic [127:0] one_round(input logic [127:0] s, input logic [127:0] k);
        logic [7:0] a [16];
        logic [7:0] b [16];
        logic [127:0] o;
        for (int i = 0; i < 16; i++) a[i] = sbx[s[127-8*i -: 8]];
        for (int c = 0; c < 4; c++)
            for (int r = 0; r < 4; r++) b[4*c+r] = a[4*((c+r)%4)+r];
        for (int c = 0; c < 4; c++) begin
            logic [7:0] p0, p1, p2, p3;
            p0 = b[4*c]; p1 = b[4*c+1]; p2 = b[4*c+2]; p3 = b[4*c+3];
            a[4*c]   = xt(p0) ^ xt(p1) ^ p1 ^ p2 ^ p3;
            a[4*c+1] = p0 ^ xt(p1) ^ xt(p2) ^ p2 ^ p3;
            a[4*c+2] = p0 ^ p1 ^ xt(p2) ^ xt(p3) ^ p3;
            a[4*c+3] = xt(p0) ^ p0 ^ p1 ^ p2 ^ xt(p3);
        end
        for (int i = 0; i < 16; i++) o[127-8*i -: 8] = a[i];
        return o ^ k;
    endfunction

    function automatic logic [127:0] key_for(input logic [2:0] m, input int r);
        if (m == 3'd7) return (r % 3 == 1) ? key_a : ((r % 3 == 2) ? key_b : key_c);
        if (m == 3'd2) return (r == 2) ? key_a : ((r == 3) ? key_b : ((r == 4) ? key_c : '0));
        return (r == 1) ? key_b : ((r == 2) ? key_a : ((r == 3) ? key_c : '0));
    endfunction

    function automatic logic [127:0] model(input logic [2:0] m, input logic [127:0] x, input logic [127:0] d);
        logic [127:0] s = x ^ d;
        int n = (m == 3'd7) ? 10 : 4;
        for (int r = 1; r <= n; r++) s = one_round(s, key_for(m, r));
        if (m >= 3'd3 && m <= 3'd6) s ^= d;
        return s;
    endfunction

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    // kind: 0 plain, 1 junk start while busy (R7), 2 offset/mode/input changes (R6)
    task automatic run(input logic [2:0] m, input logic [127:0] x, input logic [127:0] d,
                       input int kind, input int gap);
        logic [127:0] expv;
        int n;
        int exp_n;
        string tag;
        expv  = model(m, x, d);
        exp_n = (m == 3'd7) ? 11 : 5;
        for (int g = 0; g < gap; g++) begin
            @(negedge clk);
            check(done == 1'b0, "R8 done pulse", {127'd0, done}, 128'd0);
            check(y_out == prev_exp, "R8 hold", y_out, prev_exp);
        end
        mode = m; x_in = x; delta_in = d; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 1;
        while (!done && n < 40) begin
            if (kind == 1 && n == 2) begin
                start = 1'b1; x_in = rnd128(); delta_in = rnd128(); mode = 3'($urandom);
            end else begin
                start = 1'b0;
                if (kind == 2) begin
                    delta_in = rnd128(); x_in = rnd128(); mode = 3'($urandom);
                end
            end
            @(negedge clk);
            n++;
        end
        start = 1'b0;
        tag = (gap == 0) ? "R9 latency" : "R2 latency";
        check(n == exp_n, tag, 128'(n), 128'(exp_n));
        if (kind == 1)                  tag = "R7 result";
        else if (kind == 2)             tag = "R6 result";
        else if (m >= 3'd3 && m <= 3'd6) tag = "R5 result";
        else if (m == 3'd2 || m == 3'd7) tag = "R3 result";
        else                             tag = "R4 result";
        check(y_out == expv, tag, y_out, expv);
        prev_exp = expv;
    endtask

    initial begin
        for (int a = 0; a < 256; a++) begin
            logic [7:0] inv = 8'h00;
            logic [7:0] q;
            for (int c = 1; c < 256; c++)
                if (mul_slow(8'(a), 8'(c)) == 8'h01) inv = 8'(c);
            q = inv;
            for (int i = 0; i < 4; i++) begin
                inv = {inv[6:0], inv[7]};
                q ^= inv;
            end
            sbx[a] = q ^ 8'h63;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        // R1
        check(done == 1'b0, "R1 reset done", {127'd0, done}, 128'd0);
        check(y_out == '0, "R1 reset y", y_out, 128'd0);
        rst_n = 1'b1;
        @(negedge clk);
        // R4: all-zero data, zero keys
        run(3'd0, '0, '0, 0, 1);
        key_a = rnd128(); key_b = rnd128(); key_c = rnd128();
        for (int m = 0; m < 8; m++) run(3'(m), rnd128(), rnd128(), 0, (m % 2));
        run(3'd7, '1, '0, 0, 0);
        run(3'd4, '0, '1, 0, 0);
        run(3'd1, rnd128(), rnd128(), 1, 2);
        run(3'd7, rnd128(), rnd128(), 1, 0);
        run(3'd5, rnd128(), rnd128(), 2, 0);
        run(3'd7, rnd128(), rnd128(), 2, 1);
        for (int t = 0; t < 24; t++) begin
            if (t % 6 == 0) begin key_a = rnd128(); key_b = rnd128(); key_c = rnd128(); @(negedge clk); end
            run(3'($urandom), rnd128(), rnd128(), int'($urandom % 3), int'($urandom % 3));
        end
        run(3'd6, rnd128(), rnd128(), 0, 4);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule